// File: doc/BRIEF.md
# Move-Triggered Arithmetic Function Unit

This block is one arithmetic function unit for a processor whose instructions are only data moves. The move network writes the unit's operand port, and it writes the trigger port. A write to the trigger port starts an operation. The other source value is the one held in the operand register. The operation selector travels with the trigger write and picks add, subtract, low-half multiply or a bitwise logic function. The outcome enters a result register, which the move network reads as a source as often as it needs.

The operation is computed in the cycle of the trigger write. The outcome then passes through a chain of `LATENCY` registers, and each register carries a valid bit that moves with the data. The last register of the chain is the result register. Every in-flight operation carries its own copy of its inputs, so the operand register acts as a shadow. It can be rewritten while earlier operations are still in the chain. A global lock input freezes the whole unit and holds off new trigger writes.

Top module: `tta_fu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `result_o` is 0, `result_valid_o` is 0 and `fu_ready_o` is 1 when the lock is low.
- R2: An operand write without a trigger write starts nothing. `result_valid_o` stays low and `result_o` keeps its value.
- R3: A trigger write accepted in cycle c makes `result_o` show the outcome in cycle c+`LATENCY` (default 2). `result_valid_o` is high for exactly that one cycle.
- R4: Selector encoding, with A the operand and B the trigger value: 0 gives A+B, 1 gives A-B, 2 gives the low `DATA_W` bits of A*B, 3 gives A AND B, 4 gives A OR B, 5 gives A XOR B, and 6 and 7 give 0.
- R5: When an operand write and a trigger write fall in the same cycle, the new operand value is used as A for that operation.
- R6: Rewriting the operand register while an operation is in flight does not change that operation's result.
- R7: Trigger writes on consecutive cycles are all accepted. Their results come out in order, one per cycle, and at most `LATENCY` operations are in flight.
- R8: While `global_lock_i` is high, `fu_ready_o` is low. Trigger writes and operand writes are ignored, and `result_o` and every pipeline stage hold their values.
- R9: `result_o` keeps the value of the most recent completed operation until another operation completes.
- R10: `result_valid_o` is low while the lock is high. A completion that is held by the lock is signalled in the first unlocked cycle after the lock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| global_lock_i | input | 1 | Freezes the unit and blocks new moves |
| opnd_we_i | input | 1 | Move into the operand register |
| opnd_data_i | input | DATA_W | Operand value |
| trig_we_i | input | 1 | Move into the trigger register; starts an operation |
| trig_data_i | input | DATA_W | Trigger value (second source B) |
| trig_op_i | input | 3 | Operation selector, sampled with the trigger write |
| fu_ready_o | output | 1 | The unit can accept a trigger write this cycle |
| result_o | output | DATA_W | Result register, read as a move source |
| result_valid_o | output | 1 | One-cycle mark of a completed operation |

## Verification
The bench targets the following corner cases, and a design that got any of them wrong would show it at the outputs.

- **Same-cycle operand and trigger write.** A unit that reads the stale operand register here returns the previous A.
- **Operand rewritten during flight.** A unit that reads the operand late lets the later value leak into an earlier result.
- **Lock at the completion cycle, and lock with moves pending.** A unit that lets the chain slip under lock would:
  - lose or duplicate a completion, or
  - raise the valid signal while locked, or
  - accept a trigger or operand move that should have been ignored.
- **Back-to-back triggers and long idle stretches.** A unit that clears the result register or drops a stage would:
  - reorder or lose results, or
  - let `result_o` drift with no completion.

// File: rtl/tta_fu_pkg.sv
`timescale 1ns/1ps
package tta_fu_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    FU_ADD = 3'd0,
    FU_SUB = 3'd1,
    FU_MUL = 3'd2,
    FU_AND = 3'd3,
    FU_IOR = 3'd4,
    FU_XOR = 3'd5
  } fu_op_e;
endpackage

// File: rtl/tta_fu_opnd.sv
`timescale 1ns/1ps
module tta_fu_opnd #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] src_o
);
  logic [DATA_W-1:0] opnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              opnd_q <= '0;
    else if (we_i && !lock_i) opnd_q <= data_i;
  end

  // same-cycle write forwards into the triggered operation
  assign src_o = we_i ? data_i : opnd_q;
endmodule

// File: rtl/tta_fu_alu.sv
`timescale 1ns/1ps
module tta_fu_alu
  import tta_fu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (op_i)
      FU_ADD:  res_o = a_i + b_i;
      FU_SUB:  res_o = a_i - b_i;
      FU_MUL:  res_o = a_i * b_i;
      FU_AND:  res_o = a_i & b_i;
      FU_IOR:  res_o = a_i | b_i;
      FU_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/tta_fu_pipe.sv
`timescale 1ns/1ps
module tta_fu_pipe #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LATENCY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_o,
  output logic              vld_o
);
  logic [LATENCY-1:0] vld;
  logic [DATA_W-1:0]  dat [LATENCY];

  for (genvar k = 0; k < LATENCY; k++) begin : g_stg
    logic              in_v;
    logic [DATA_W-1:0] in_d;
    logic              v_q;
    logic [DATA_W-1:0] d_q;

    if (k == 0) begin : g_head
      assign in_v = start_i;
      assign in_d = data_i;
    end else begin : g_body
      assign in_v = vld[k-1];
      assign in_d = dat[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (!lock_i) begin
        v_q <= in_v;
        if (in_v) d_q <= in_d;
      end
    end

    assign vld[k] = v_q;
    assign dat[k] = d_q;
  end

  assign res_o = dat[LATENCY-1];
  assign vld_o = vld[LATENCY-1];
endmodule

// File: rtl/tta_fu.sv
`timescale 1ns/1ps
module tta_fu
  import tta_fu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LATENCY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              global_lock_i,
  input  logic              opnd_we_i,
  input  logic [DATA_W-1:0] opnd_data_i,
  input  logic              trig_we_i,
  input  logic [DATA_W-1:0] trig_data_i,
  input  logic [OP_W-1:0]   trig_op_i,
  output logic              fu_ready_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);
  logic [DATA_W-1:0] src_a;
  logic [DATA_W-1:0] alu_res;
  logic              start;
  logic              last_vld;

  assign start = trig_we_i && !global_lock_i;

  tta_fu_opnd #(.DATA_W(DATA_W)) u_opnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (global_lock_i),
    .we_i   (opnd_we_i),
    .data_i (opnd_data_i),
    .src_o  (src_a)
  );

  tta_fu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (trig_op_i),
    .a_i   (src_a),
    .b_i   (trig_data_i),
    .res_o (alu_res)
  );

  tta_fu_pipe #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (global_lock_i),
    .start_i (start),
    .data_i  (alu_res),
    .res_o   (result_o),
    .vld_o   (last_vld)
  );

  assign fu_ready_o     = !global_lock_i;
  assign result_valid_o = last_vld && !global_lock_i;
endmodule

// File: rtl/tta_fu_chk.sv
`timescale 1ns/1ps
module tta_fu_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LATENCY = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              global_lock_i,
  input logic              opnd_we_i,
  input logic [DATA_W-1:0] opnd_data_i,
  input logic              trig_we_i,
  input logic [DATA_W-1:0] trig_data_i,
  input logic [2:0]        trig_op_i,
  input logic              fu_ready_o,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 2);
  logic [CNT_W-1:0] inflight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight <= '0;
    else if ((trig_we_i && !global_lock_i) && !result_valid_o) inflight <= inflight + 1'b1;
    else if (!(trig_we_i && !global_lock_i) && result_valid_o) inflight <= inflight - 1'b1;
  end

  AST_VALID_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> inflight != '0);                                        // R3

  AST_INFLIGHT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight <= CNT_W'(LATENCY));                                              // R7

  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    global_lock_i |=> $stable(result_o));                                      // R8

  AST_OPND_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_we_i && !trig_we_i && inflight == '0) |=> !result_valid_o);          // R2

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(result_o) && !global_lock_i) |-> result_valid_o);                // R9
endmodule

bind tta_fu tta_fu_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_chk (.*);

// File: tb/tb_tta_fu.sv
`timescale 1ns/1ps
module tb_tta_fu;
  localparam int DW  = 32;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lock = 1'b0;
  logic          owe = 1'b0;
  logic [DW-1:0] odat = '0;
  logic          twe = 1'b0;
  logic [DW-1:0] tdat = '0;
  logic [2:0]    top = '0;
  logic          fu_ready;
  logic [DW-1:0] result;
  logic          result_valid;

  tta_fu #(.DATA_W(DW), .LATENCY(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .global_lock_i(lock),
    .opnd_we_i(owe), .opnd_data_i(odat),
    .trig_we_i(twe), .trig_data_i(tdat), .trig_op_i(top),
    .fu_ready_o(fu_ready), .result_o(result), .result_valid_o(result_valid)
  );

  always #10 clk = ~clk;

  int            n_tests = 0;
  int            n_fail  = 0;
  string         cur_req = "R1";
  logic [DW-1:0] opnd_m  = '0;
  logic [DW-1:0] exp_res = '0;
  logic [DW-1:0] q_val[$];
  int            q_age[$];

  function automatic logic [DW-1:0] ref_op(logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a * b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      default: return '0;
    endcase
  endfunction

  task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(logic lk, logic ow, logic [DW-1:0] od, logic tw, logic [DW-1:0] td, logic [2:0] op);
    logic ev;
    logic [DW-1:0] a;
    @(negedge clk);
    lock = lk; owe = ow; odat = od; twe = tw; tdat = td; top = op;
    #1;
    ev = (q_val.size() > 0) && (q_age[0] == LAT) && !lk;
    chk(result_valid == ev, "result_valid", DW'(result_valid), DW'(ev));
    chk(result == exp_res, "result", result, exp_res);
    chk(fu_ready == !lk, "fu_ready", DW'(fu_ready), DW'(!lk));
    @(posedge clk);
    if (!lk) begin
      if (q_val.size() > 0 && q_age[0] == LAT) begin
        void'(q_val.pop_front());
        void'(q_age.pop_front());
      end
      foreach (q_age[i]) q_age[i]++;
      if (tw) begin
        a = ow ? od : opnd_m;
        q_val.push_back(ref_op(op, a, td));
        q_age.push_back(1);
      end
      if (ow) opnd_m = od;
      if (q_val.size() > 0 && q_age[0] == LAT) exp_res = q_val[0];
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, '0, 3'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result == '0, "reset result", result, '0);
    chk(result_valid == 1'b0, "reset valid", DW'(result_valid), '0);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2";  // operand-only writes start nothing
    step(1'b0, 1'b1, 32'h11, 1'b0, '0, 3'd0);
    step(1'b0, 1'b1, 32'h22, 1'b0, '0, 3'd0);
    idle(LAT + 1);

    cur_req = "R3";  // trigger uses latched operand 0x22
    step(1'b0, 1'b0, '0, 1'b1, 32'h100, 3'd0);
    idle(LAT + 1);

    cur_req = "R4";  // every selector code
    for (int op = 0; op < 8; op++) begin
      step(1'b0, 1'b1, 32'hF0F0_1234, 1'b0, '0, 3'd0);
      step(1'b0, 1'b0, '0, 1'b1, 32'h0FF0_0007, op[2:0]);
      idle(LAT);
    end

    cur_req = "R5";  // same-cycle operand and trigger
    step(1'b0, 1'b1, 32'd7, 1'b0, '0, 3'd0);
    step(1'b0, 1'b1, 32'd1000, 1'b1, 32'd5, 3'd1);
    idle(LAT + 1);

    cur_req = "R6";  // operand rewritten while in flight
    step(1'b0, 1'b0, '0, 1'b1, 32'd3, 3'd2);
    step(1'b0, 1'b1, 32'hDEAD, 1'b0, '0, 3'd0);
    step(1'b0, 1'b1, 32'hBEEF, 1'b0, '0, 3'd0);
    idle(LAT + 1);

    cur_req = "R7";  // back-to-back triggers
    for (int i = 0; i < 6; i++)
      step(1'b0, i[0], $urandom, 1'b1, $urandom, 3'($urandom_range(0, 7)));
    idle(LAT + 1);

    cur_req = "R8";  // lock with pending moves
    step(1'b0, 1'b1, 32'd9, 1'b1, 32'd4, 3'd0);
    step(1'b1, 1'b1, 32'h777, 1'b1, 32'h555, 3'd4);
    step(1'b1, 1'b1, 32'h888, 1'b1, 32'h666, 3'd4);
    step(1'b1, 1'b0, '0, 1'b0, '0, 3'd0);
    idle(LAT + 1);
    step(1'b0, 1'b0, '0, 1'b1, 32'd1, 3'd0);  // exposes operand: 9 expected
    idle(LAT + 1);

    cur_req = "R10";  // lock lands on completion cycle
    step(1'b0, 1'b1, 32'd50, 1'b1, 32'd8, 3'd0);
    for (int i = 1; i < LAT; i++) step(1'b0, 1'b0, '0, 1'b0, '0, 3'd0);
    step(1'b1, 1'b0, '0, 1'b0, '0, 3'd0);
    step(1'b1, 1'b0, '0, 1'b0, '0, 3'd0);
    idle(LAT + 1);

    cur_req = "R9";  // result holds through idle
    idle(20);

    cur_req = "R7";  // constrained random mix
    for (int i = 0; i < 400; i++)
      step(($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0), $urandom,
           ($urandom_range(0, 1) == 0), $urandom, 3'($urandom_range(0, 7)));
    idle(LAT + 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule